// File: doc/BRIEF.md
# Software write protection sequencer

This block sits between the write front end of a parallel nonvolatile byte memory and its page programming controller. Every recognised byte load (an address and a data byte) is shown to it. It reports, one clock later, whether that load was a step of a command sequence, is to be taken into the page buffer as data, or has been thrown away.

A persistent protection flag decides how data loads are treated. With protection off, every load is written, and the command steps are written too. With protection on, a load is written only inside a burst that a three-step unlock opens. A load that is neither an unlock step nor inside an open burst is discarded.

The three-step unlock also switches protection on. A six-step sequence switches it off. The flag is not cleared by the functional reset. It is loaded from a separate preset input that stands for the value kept across power loss. All loads are refused during a start-up inhibit period after the supply-good input rises, and while the supply-low input is high.

Top module: `swp_sequencer`

## Requirements
- R1: After reset, `load_accept`, `load_cmd`, `load_block` and `unlock_open` are 0, and no command sequence is in progress.
- R2: With protection off, every load that is not inhibited is reported with `load_accept`=1 in the cycle after the load. `load_cmd`=1 is added when the load is a sequence step.
- R3: The loads 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 set `prot_on` to 1 in the same cycle as the third `load_cmd` pulse. They also set `unlock_open`. `prot_on` stays 1 whether or not data loads follow.
- R4: With protection on and no burst open, a load that is not a sequence step gives `load_block`=1 and `load_accept`=0.
- R5: With protection on, sequence steps give `load_cmd`=1 and `load_accept`=0. After the three-step unlock, data loads give `load_accept`=1 for as long as each one arrives within WINDOW_CYC cycles of the load before it.
- R6: When WINDOW_CYC cycles pass with no load, an open burst closes (`unlock_open`=0) and a sequence in progress is abandoned.
- R7: The loads 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 clear `prot_on` in the cycle of the sixth `load_cmd` pulse. Loads after that are accepted.
- R8: A load that does not match the expected next step abandons the sequence. The same load is then tested as a first step (0xAA@0x5555), and if it matches, a new sequence starts.
- R9: `rst_n` does not change `prot_on`. `nv_load`=1 copies `nv_value` into `prot_on` at the next clock edge.
- R10: `write_inhibit` is 1 while `supply_good` is low, while `supply_low` is high, and for INHIBIT_CYC cycles after `supply_good` rises or reset is released. A load made during inhibit gives `load_block`=1 and changes neither the sequence state nor the flag.
- R11: The result pulses last one cycle and appear only in the cycle after a load. `load_block` is never high together with `load_accept` or `load_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| nv_load | input | 1 | Load the protection flag from `nv_value` |
| nv_value | input | 1 | Protection value kept across power loss |
| supply_good | input | 1 | Supply has reached its operating level |
| supply_low | input | 1 | Supply is below the write threshold |
| load_valid | input | 1 | One byte load event this cycle |
| load_addr | input | 15 | Address of the load |
| load_data | input | 8 | Data of the load |
| load_cmd | output | 1 | Previous load was a command sequence step |
| load_accept | output | 1 | Previous load goes to the page buffer as data |
| load_block | output | 1 | Previous load was discarded |
| prot_on | output | 1 | Protection flag |
| unlock_open | output | 1 | An unlocked write burst is open |
| write_inhibit | output | 1 | Writes refused because of supply state |

## Verification
Internal state shows at the ports one cycle after the next load. If the step counter is wrong, a later sequence step comes back as blocked or as data instead of as a command. If the burst window is wrong, a data load after an idle gap is accepted or refused when it should not be. If the flag is wrong, the next ordinary load is accepted or blocked against expectation. Sequences are therefore driven with mismatches part way through and with gaps on both sides of the window. Power events are placed between sequence steps, so that any state that leaks through them shows up in the result of the very next load.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int unsigned ADDR_W = 15;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_HI = 15'h5555;
  localparam logic [ADDR_W-1:0] ADR_LO = 15'h2AAA;

  localparam logic [DATA_W-1:0] K_OPEN  = 8'hAA;
  localparam logic [DATA_W-1:0] K_KEY   = 8'h55;
  localparam logic [DATA_W-1:0] K_ARM   = 8'hA0;
  localparam logic [DATA_W-1:0] K_ERASE = 8'h80;
  localparam logic [DATA_W-1:0] K_CLEAR = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_A1   = 3'd1,
    ST_A2   = 3'd2,
    ST_D3   = 3'd3,
    ST_D4   = 3'd4,
    ST_D5   = 3'd5
  } step_e;
endpackage

// File: rtl/swp_seq_match.sv
module swp_seq_match
  import swp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              adv,
  input  logic              abort,
  output logic              hit,
  output logic              enable_done,
  output logic              disable_done
);
  step_e step_q, step_d, cur, nxt;
  logic  is_open, is_key, is_arm, is_erase, is_clear;

  assign is_open  = (ld_addr == ADR_HI) && (ld_data == K_OPEN);
  assign is_key   = (ld_addr == ADR_LO) && (ld_data == K_KEY);
  assign is_arm   = (ld_addr == ADR_HI) && (ld_data == K_ARM);
  assign is_erase = (ld_addr == ADR_HI) && (ld_data == K_ERASE);
  assign is_clear = (ld_addr == ADR_HI) && (ld_data == K_CLEAR);

  assign cur = abort ? ST_IDLE : step_q;

  always_comb begin
    hit          = 1'b0;
    enable_done  = 1'b0;
    disable_done = 1'b0;
    nxt          = ST_IDLE;
    unique case (cur)
      ST_IDLE: if (is_open) begin hit = 1'b1; nxt = ST_A1; end
      ST_A1:   if (is_key)  begin hit = 1'b1; nxt = ST_A2; end
      ST_A2: begin
        if (is_arm) begin
          hit = 1'b1; enable_done = 1'b1;
        end else if (is_erase) begin
          hit = 1'b1; nxt = ST_D3;
        end
      end
      ST_D3:   if (is_open) begin hit = 1'b1; nxt = ST_D4; end
      ST_D4:   if (is_key)  begin hit = 1'b1; nxt = ST_D5; end
      ST_D5:   if (is_clear) begin hit = 1'b1; disable_done = 1'b1; end
      default: nxt = ST_IDLE;
    endcase
    // mismatch mid-sequence: retry the same load as a first step
    if (!hit && (cur != ST_IDLE) && is_open) begin
      hit = 1'b1;
      nxt = ST_A1;
    end
  end

  always_comb begin
    step_d = adv ? nxt : cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_IDLE;
    else        step_q <= step_d;
  end

  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= ST_D5) else $error("step out of range"); // R8

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(abort && !adv)) |-> (step_q == ST_IDLE)) else $error("abort kept step"); // R6
endmodule

// File: rtl/swp_window_timer.sv
module swp_window_timer #(
  parameter int unsigned WINDOW_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expired
);
  localparam int unsigned CNT_W = $clog2(WINDOW_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == LIMIT);
  assign cnt_en  = kick || !expired;

  always_comb begin
    cnt_d = kick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LIMIT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT) else $error("window counter overran"); // R6
endmodule

// File: rtl/swp_power_gate.sv
module swp_power_gate #(
  parameter int unsigned INHIBIT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_good,
  input  logic supply_low,
  output logic inhibit
);
  localparam int unsigned CNT_W = $clog2(INHIBIT_CYC + 1);
  localparam logic [CNT_W-1:0] START = CNT_W'(INHIBIT_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en  = !supply_good || (cnt_q != '0);
  assign inhibit = !supply_good || supply_low || (cnt_q != '0);

  always_comb begin
    cnt_d = supply_good ? cnt_q - 1'b1 : START;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= START;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_INHIBIT_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_good) |=> inhibit) else $error("no start-up inhibit"); // R10
endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer
  import swp_pkg::*;
#(
  parameter int unsigned WINDOW_CYC  = 40,
  parameter int unsigned INHIBIT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_load,
  input  logic              nv_value,
  input  logic              supply_good,
  input  logic              supply_low,
  input  logic              load_valid,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic              load_cmd,
  output logic              load_accept,
  output logic              load_block,
  output logic              prot_on,
  output logic              unlock_open,
  output logic              write_inhibit
);
  logic rst_meta_q, rst_sync_n;
  logic inhibit, expired, hit, en_done, dis_done;
  logic ld, eff_unl, adv;
  logic acc_d, cmd_d, blk_d, acc_q, cmd_q, blk_q;
  logic prot_q, prot_d, unl_q, unl_d;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  swp_power_gate #(.INHIBIT_CYC(INHIBIT_CYC)) u_gate (
    .clk(clk), .rst_n(rst_sync_n), .supply_good(supply_good),
    .supply_low(supply_low), .inhibit(inhibit)
  );

  swp_window_timer #(.WINDOW_CYC(WINDOW_CYC)) u_window (
    .clk(clk), .rst_n(rst_sync_n), .kick(ld), .expired(expired)
  );

  swp_seq_match u_match (
    .clk(clk), .rst_n(rst_sync_n), .ld_addr(load_addr), .ld_data(load_data),
    .adv(adv), .abort(expired), .hit(hit), .enable_done(en_done),
    .disable_done(dis_done)
  );

  // decision for the current load
  always_comb begin
    ld      = load_valid && !inhibit;
    eff_unl = unl_q && !expired;
    adv     = ld && !(prot_q && eff_unl);
    acc_d   = ld && (!prot_q || eff_unl);
    cmd_d   = adv && hit;
    blk_d   = load_valid && (inhibit || (prot_q && !eff_unl && !hit));

    prot_d = prot_q;
    if (adv && en_done)       prot_d = 1'b1;
    else if (adv && dis_done) prot_d = 1'b0;

    unl_d = eff_unl;
    if (nv_load)              unl_d = 1'b0;
    else if (adv && en_done)  unl_d = 1'b1;
    else if (adv && dis_done) unl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= 1'b0;
      cmd_q <= 1'b0;
      blk_q <= 1'b0;
      unl_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cmd_q <= cmd_d;
      blk_q <= blk_d;
      unl_q <= unl_d;
    end
  end

  // persistent flag: outside the functional reset
  always_ff @(posedge clk) begin
    if (nv_load)         prot_q <= nv_value;
    else if (rst_sync_n) prot_q <= prot_d;
  end

  assign load_accept   = acc_q;
  assign load_cmd      = cmd_q;
  assign load_block    = blk_q;
  assign prot_on       = prot_q;
  assign unlock_open   = unl_q;
  assign write_inhibit = inhibit;

  AST_BLOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    blk_q |-> (!acc_q && !cmd_q)) else $error("block with accept or cmd"); // R11

  AST_PULSE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_q || cmd_q || blk_q) |-> $past(load_valid)) else $error("pulse without load"); // R11

  AST_PROT_SET_BY_CMD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(prot_q) && !$past(nv_load)) |-> cmd_q) else $error("flag set without command"); // R3

  AST_PROT_CLR_BY_CMD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($fell(prot_q) && !$past(nv_load)) |-> cmd_q) else $error("flag cleared without command"); // R7

  AST_UNLOCK_NEEDS_PROT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unl_q |-> prot_q) else $error("burst open while unprotected"); // R5

  AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(load_valid && inhibit)) |-> blk_q) else $error("inhibited load passed"); // R10
endmodule

// File: tb/test_swp_sequencer.sv
`timescale 1ns/1ps
module test_swp_sequencer;
  localparam int W   = 40;
  localparam int INH = 1000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, nv_load, nv_value, supply_good, supply_low, load_valid;
  logic [14:0] load_addr;
  logic [7:0]  load_data;
  logic        load_cmd, load_accept, load_block, prot_on, unlock_open, write_inhibit;

  int   vectors = 0;
  int   miscompares = 0;
  logic r_acc, r_cmd, r_blk;

  swp_sequencer #(.WINDOW_CYC(W), .INHIBIT_CYC(INH)) i_swp_sequencer (
    .clk(clk), .rst_n(rst_n), .nv_load(nv_load), .nv_value(nv_value),
    .supply_good(supply_good), .supply_low(supply_low), .load_valid(load_valid),
    .load_addr(load_addr), .load_data(load_data), .load_cmd(load_cmd),
    .load_accept(load_accept), .load_block(load_block), .prot_on(prot_on),
    .unlock_open(unlock_open), .write_inhibit(write_inhibit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ld(input logic [14:0] a, input logic [7:0] d,
                    input logic ea, input logic ec, input logic eb, input string tag);
    @(negedge clk);
    load_valid = 1'b1; load_addr = a; load_data = d;
    @(negedge clk);
    load_valid = 1'b0;
    r_acc = load_accept; r_cmd = load_cmd; r_blk = load_block;
    chk({tag, " accept"}, r_acc, ea);
    chk({tag, " cmd"},    r_cmd, ec);
    chk({tag, " block"},  r_blk, eb);
  endtask

  task automatic t_reset;
    chk("R1 accept after reset", load_accept, 1'b0);
    chk("R1 cmd after reset",    load_cmd,    1'b0);
    chk("R1 block after reset",  load_block,  1'b0);
    chk("R1 unlock after reset", unlock_open, 1'b0);
    chk("R9 preset flag",        prot_on,     1'b0);
  endtask

  task automatic t_startup_inhibit;
    chk("R10 inhibit at start", write_inhibit, 1'b1);
    ld(15'h0100, 8'h12, 0, 0, 1, "R10 load during start-up");
    idle(INH + 20);
    chk("R10 inhibit released", write_inhibit, 1'b0);
  endtask

  task automatic t_unprotected;
    ld(15'h0100, 8'h12, 1, 0, 0, "R2 plain load");
    ld(15'h7FFF, 8'h00, 1, 0, 0, "R2 top address");
    idle(1);
    chk("R11 no pulse when idle", {load_accept, load_cmd, load_block}, 3'b000);
    ld(15'h5555, 8'hAA, 1, 1, 0, "R2 step written as data");
    idle(W + 10);
  endtask

  task automatic t_enable;
    ld(15'h5555, 8'hAA, 1, 1, 0, "R3 step1");
    ld(15'h2AAA, 8'h55, 1, 1, 0, "R3 step2");
    chk("R3 flag before step3", prot_on, 1'b0);
    ld(15'h5555, 8'hA0, 1, 1, 0, "R3 step3");
    chk("R3 flag after step3", prot_on, 1'b1);
    chk("R3 burst open", unlock_open, 1'b1);
    idle(W + 10);
    chk("R6 burst closed", unlock_open, 1'b0);
    chk("R3 flag held without data", prot_on, 1'b1);
    ld(15'h0200, 8'h34, 0, 0, 1, "R4 protected plain load");
  endtask

  task automatic t_burst;
    ld(15'h5555, 8'hAA, 0, 1, 0, "R5 unlock1");
    ld(15'h2AAA, 8'h55, 0, 1, 0, "R5 unlock2");
    ld(15'h5555, 8'hA0, 0, 1, 0, "R5 unlock3");
    ld(15'h0300, 8'h01, 1, 0, 0, "R5 data0");
    idle(5);
    ld(15'h0301, 8'h02, 1, 0, 0, "R5 data1 after gap");
    ld(15'h5555, 8'hAA, 1, 0, 0, "R5 command-like data in burst");
    idle(W + 10);
    ld(15'h0302, 8'h03, 0, 0, 1, "R6 data after window");
  endtask

  task automatic t_abort;
    ld(15'h5555, 8'hAA, 0, 1, 0, "R8 first");
    ld(15'h1234, 8'h55, 0, 0, 1, "R8 wrong address");
    ld(15'h2AAA, 8'h55, 0, 0, 1, "R8 second without first");
    ld(15'h5555, 8'hAA, 0, 1, 0, "R8 restart");
    ld(15'h5555, 8'hAA, 0, 1, 0, "R8 mismatch retried as first");
    ld(15'h2AAA, 8'h55, 0, 1, 0, "R8 step2");
    ld(15'h5555, 8'hA0, 0, 1, 0, "R8 step3");
    ld(15'h0400, 8'h77, 1, 0, 0, "R8 data after recovered unlock");
    idle(W + 10);
    ld(15'h5555, 8'hAA, 0, 1, 0, "R6 step then stall");
    idle(W + 10);
    ld(15'h2AAA, 8'h55, 0, 0, 1, "R6 stalled sequence dropped");
  endtask

  task automatic t_power;
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    chk("R9 flag kept in reset", prot_on, 1'b1);
    rst_n = 1'b1;
    idle(INH + 20);
    chk("R9 flag kept after reset", prot_on, 1'b1);
    supply_low = 1'b1;
    idle(1);
    chk("R10 supply low inhibit", write_inhibit, 1'b1);
    ld(15'h5555, 8'hAA, 0, 0, 1, "R10 step under supply low");
    supply_low = 1'b0;
    ld(15'h2AAA, 8'h55, 0, 0, 1, "R10 blocked step not counted");
    ld(15'h5555, 8'hA0, 0, 0, 1, "R10 no unlock");
    chk("R10 flag unchanged", prot_on, 1'b1);
    supply_good = 1'b0;
    idle(5);
    supply_good = 1'b1;
    idle(10);
    ld(15'h5555, 8'hAA, 0, 0, 1, "R10 inside start-up window");
    idle(INH + 10);
    ld(15'h5555, 8'hAA, 0, 1, 0, "R10 after start-up window");
    idle(W + 10);
  endtask

  task automatic t_disable;
    ld(15'h5555, 8'hAA, 0, 1, 0, "R7 d1");
    ld(15'h2AAA, 8'h55, 0, 1, 0, "R7 d2");
    ld(15'h5555, 8'h80, 0, 1, 0, "R7 d3");
    ld(15'h5555, 8'hAA, 0, 1, 0, "R7 d4");
    ld(15'h2AAA, 8'h55, 0, 1, 0, "R7 d5");
    chk("R7 flag before d6", prot_on, 1'b1);
    ld(15'h5555, 8'h20, 0, 1, 0, "R7 d6");
    chk("R7 flag after d6", prot_on, 1'b0);
    chk("R7 no burst", unlock_open, 1'b0);
    ld(15'h0500, 8'h5A, 1, 0, 0, "R7 write after disable");
  endtask

  task automatic t_preset;
    @(negedge clk); nv_load = 1'b1; nv_value = 1'b1;
    @(negedge clk); nv_load = 1'b0;
    chk("R9 preset to on", prot_on, 1'b1);
    ld(15'h0600, 8'h11, 0, 0, 1, "R4 blocked after preset");
    @(negedge clk); nv_load = 1'b1; nv_value = 1'b0;
    @(negedge clk); nv_load = 1'b0;
    chk("R9 preset to off", prot_on, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nv_load = 1'b1; nv_value = 1'b0;
    supply_good = 1'b1; supply_low = 1'b0;
    load_valid = 1'b0; load_addr = '0; load_data = '0;
    idle(4);
    nv_load = 1'b0;
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_startup_inhibit();
    t_unprotected();
    t_enable();
    t_burst();
    t_abort();
    t_power();
    t_disable();
    t_preset();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule